// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a controller's transmit-data line and the driver enable of a single-wire, open-drain style bus transceiver. While transmission is enabled by the mode controller, a low transmit level turns the driver on, which makes the bus dominant. A high level leaves the driver off, so the bus stays recessive. The block also copies the sensed bus level to a receive output for the controller.

A stuck-low transmit line would hold the whole bus dominant and block every other node. To prevent this, the guard counts timebase ticks while transmit data is low and enabled. Once the low time goes past a limit, the driver is forced off and a timeout flag is raised. The block then stays locked. It leaves the lock only after transmit data has been high for longer than a release time. A brief high pulse does not unlock it and restarts the release count. Both durations are parameters measured in ticks of an external timebase strobe.

Top module: `txd_dom_guard`

## Requirements
- R1: One cycle after an edge at which transmit is enabled, `txd_i` is 0 (0 means dominant) and the guard is not locked, `drv_on_o` is 1. In every other case it is 0.
- R2: The guard locks at the tick edge that finds the dominant count equal to `DOM_TICKS`, which is the (`DOM_TICKS`+1)th tick with `txd_i` low and transmit enabled. Exactly `DOM_TICKS` such ticks do not lock it.
- R3: `timeout_o` is 1 from the lock edge until the release edge. While it is 1, `drv_on_o` stays 0 whatever `txd_i` is.
- R4: A locked guard is released at the tick edge that finds `REL_TICKS` ticks already counted with `txd_i` high, which is the (`REL_TICKS`+1)th consecutive such tick. Any cycle with `txd_i` low clears the release count. Release does not depend on transmit enable.
- R5: `rxd_o` equals the value of `bus_sense_i` at the previous clock edge (1 means recessive). This holds whether or not transmit is enabled.
- R6: The dominant count advances only on cycles with `tick_i` at 1. It is cleared whenever `txd_i` is high or transmit is disabled. A disabled transmitter held low never locks.
- R7: While `rst_n` is low, `drv_on_o` is 0, `rxd_o` is 1 and `timeout_o` is 0. Any lock and any counts are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| tx_en_i | input | 1 | Transmit enable from the mode controller (normal mode) |
| bus_sense_i | input | 1 | Sensed bus level, 1 = recessive |
| tick_i | input | 1 | One-cycle timebase strobe |
| drv_on_o | output | 1 | Bus driver on (pulls the bus dominant) |
| rxd_o | output | 1 | Receive data to the controller |
| timeout_o | output | 1 | Dominant timeout lock active |

## Verification
The bench holds transmit low for exactly the limit and then for one tick more. A design off by one in the trip compare would lock too early or one tick late. Cycles without a tick are mixed in, so a counter that advances on the clock instead of the timebase would trip early. A short high pulse is placed inside the release window; a design that releases on a rising edge, or that does not restart the count, would drop the flag too soon. The bench also releases a lock with transmit disabled, holds a disabled line low past the limit, and resets while locked. These catch a lock that depends on the enable and a lock that survives reset.

// File: rtl/txd_dom_guard_pkg.sv
package txd_dom_guard_pkg;

  typedef enum logic [0:0] {
    GS_ACTIVE = 1'b0,
    GS_LOCKED = 1'b1
  } guard_state_t;

  // saturating increment for a count of up to 16 bits
  function automatic logic [15:0] sat_inc(input logic [15:0] cur, input logic [15:0] lim);
    sat_inc = (cur >= lim) ? lim : cur + 16'd1;
  endfunction

  // a tick that arrives with the count already at its limit ends the window
  function automatic logic window_done(input logic strobe, input logic [15:0] cur,
                                       input logic [15:0] lim);
    window_done = strobe && (cur == lim);
  endfunction

  // the driver only pulls the bus when enabled, data low and not locked
  function automatic logic drive_level(input logic en, input logic data, input guard_state_t st);
    drive_level = en && !data && (st == GS_ACTIVE);
  endfunction

endpackage

// File: rtl/txd_tick_window.sv
module txd_tick_window #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic done
);
  import txd_dom_guard_pkg::*;

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0]  cnt_q;
  logic [15:0]   cnt_ext;
  logic [15:0]   lim_ext;
  logic [15:0]   nxt_ext;

  assign cnt_ext = 16'(cnt_q);
  assign lim_ext = 16'(LIMIT);
  assign nxt_ext = sat_inc(cnt_ext, lim_ext);
  assign done    = arm && window_done(tick, cnt_ext, lim_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= nxt_ext[W-1:0];
    end
  end

endmodule

// File: rtl/txd_guard_fsm.sv
module txd_guard_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic release_ok,
  input  logic txd,
  input  logic tx_en,
  output logic locked,
  output logic drv_on
);
  import txd_dom_guard_pkg::*;

  guard_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_ACTIVE: if (trip)       st_d = GS_LOCKED;
      GS_LOCKED: if (release_ok) st_d = GS_ACTIVE;
      default:                   st_d = GS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_ACTIVE;
      drv_on <= 1'b0;
    end else begin
      st_q   <= st_d;
      drv_on <= drive_level(tx_en, txd, st_d);
    end
  end

  assign locked = (st_q == GS_LOCKED);

endmodule

// File: rtl/txd_rx_mirror.sv
module txd_rx_mirror (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sense,
  output logic rxd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxd <= 1'b1;
    else        rxd <= bus_sense;
  end
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int DOM_TICKS = 27000,
  parameter int REL_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic tx_en_i,
  input  logic bus_sense_i,
  input  logic tick_i,
  output logic drv_on_o,
  output logic rxd_o,
  output logic timeout_o
);

  logic locked_w;
  logic dom_arm_w;
  logic rel_arm_w;
  logic trip_w;
  logic release_w;

  // dominant window runs only while enabled, low and unlocked
  assign dom_arm_w = tx_en_i && !txd_i && !locked_w;
  // release window runs only while locked with data high
  assign rel_arm_w = locked_w && txd_i;

  txd_tick_window #(.LIMIT(DOM_TICKS)) dom_win_i (
    .clk(clk), .rst_n(rst_n), .arm(dom_arm_w), .tick(tick_i), .done(trip_w)
  );

  txd_tick_window #(.LIMIT(REL_TICKS)) rel_win_i (
    .clk(clk), .rst_n(rst_n), .arm(rel_arm_w), .tick(tick_i), .done(release_w)
  );

  txd_guard_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .trip(trip_w), .release_ok(release_w),
    .txd(txd_i), .tx_en(tx_en_i), .locked(locked_w), .drv_on(drv_on_o)
  );

  txd_rx_mirror rx_i (
    .clk(clk), .rst_n(rst_n), .bus_sense(bus_sense_i), .rxd(rxd_o)
  );

  assign timeout_o = locked_w;

endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic txd_i,
  input logic tx_en_i,
  input logic bus_sense_i,
  input logic tick_i,
  input logic drv_on_o,
  input logic rxd_o,
  input logic timeout_o,
  input logic trip_w,
  input logic release_w
);

  // R1: driver on only after an enabled low transmit level
  a_r1_drive_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    drv_on_o |-> $past(tx_en_i && !txd_i));

  // R3: lock keeps the driver off
  a_r3_lock_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !drv_on_o);

  // R2: a lock starts only from a ticked low level
  a_r2_lock_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(!txd_i && tick_i));

  // R4: a lock ends only from a ticked high level
  a_r4_release_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_o) |-> $past(txd_i && tick_i));

  // R5: receive output follows the sensed bus one edge later
  a_r5_rx_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rxd_o == $past(bus_sense_i)));

  // R2 R4: trip and release never fire together
  a_r4_trip_release_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trip_w, release_w}));

endmodule

bind txd_dom_guard txd_dom_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .txd_i(txd_i), .tx_en_i(tx_en_i),
  .bus_sense_i(bus_sense_i), .tick_i(tick_i), .drv_on_o(drv_on_o),
  .rxd_o(rxd_o), .timeout_o(timeout_o), .trip_w(trip_w), .release_w(release_w)
);

// File: tb/txd_dom_guard_tb.sv
module txd_dom_guard_tb_top;

  localparam int DOM = 3;
  localparam int REL = 2;
  localparam int NV  = 33;

  // {tx_en, txd, bus, tick, exp_drv, exp_rx, exp_to}
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b1111_010, 7'b1001_100, 7'b1000_100, 7'b1001_100, 7'b1001_100,
    7'b1001_001, 7'b1011_011, 7'b1111_011, 7'b1011_011, 7'b1111_011,
    7'b1111_011, 7'b1110_011, 7'b1111_010, 7'b1001_100, 7'b1111_010,
    7'b1001_100, 7'b1001_100, 7'b1001_100, 7'b1111_010, 7'b0011_010,
    7'b0011_010, 7'b0011_010, 7'b0011_010, 7'b0011_010, 7'b1001_100,
    7'b0101_000, 7'b1001_100, 7'b1001_100, 7'b1001_100, 7'b1001_001,
    7'b0111_011, 7'b0111_011, 7'b0111_010
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, tx_en = 1'b0, bus = 1'b1, tick = 1'b0;
  logic drv_on, rxd, tmo;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  txd_dom_guard #(.DOM_TICKS(DOM), .REL_TICKS(REL)) dut_i (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .tx_en_i(tx_en),
    .bus_sense_i(bus), .tick_i(tick), .drv_on_o(drv_on),
    .rxd_o(rxd), .timeout_o(tmo)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: drv/rx/to got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic d, input logic b, input logic t);
    tx_en = en; txd = d; bus = b; tick = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R7 reset", {drv_on, rxd, tmo}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 drive, R2 trip at DOM+1 ticks, R3 lock, R4 release with glitch,
    // R5 rx mirror, R6 tick gating and enable clearing
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      check($sformatf("R1 R2 R3 R4 R5 R6 vector %0d", i), {drv_on, rxd, tmo}, VEC[i][2:0]);
    end

    // R6: ticks absent for many cycles while low never trip
    step(1, 0, 0, 1);
    for (int k = 0; k < 20; k++) step(1, 0, 0, 0);
    check("R6 no tick no trip", {drv_on, rxd, tmo}, 3'b100);

    // R7: reset while locked clears the lock
    for (int k = 0; k < DOM; k++) step(1, 0, 0, 1);
    check("R2 trip pending", {drv_on, rxd, tmo}, 3'b001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 reset clears lock", {drv_on, rxd, tmo}, 3'b010);
    rst_n = 1'b1;
    step(1, 0, 0, 1);
    check("R1 drive after reset", {drv_on, rxd, tmo}, 3'b100);

    // R4: repeated glitches inside the release window keep the lock
    step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 0, 0, 1);
    check("R2 lock again", {drv_on, rxd, tmo}, 3'b001);
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 1, 1); step(1, 1, 1, 1); step(1, 0, 1, 1);
    end
    check("R4 glitches hold lock", {drv_on, rxd, tmo}, 3'b011);
    step(1, 1, 1, 1); step(1, 1, 1, 1); step(1, 1, 1, 1);
    check("R4 release", {drv_on, rxd, tmo}, 3'b010);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule